// File: doc/BRIEF.md
# Power-On Strap Capture for a Shared Clock Pin

This block controls one package pin that does two jobs. For a fixed window after the supply is declared good, the pin is an input: its driver is held in high impedance so an external pull resistor sets the pin level. At the end of the window, the block stores that level once. It then enables the driver, so the reference clock appears on the pin.

The stored bit chooses the rate of a companion clock output: 24 MHz when the stored bit is 1, and 48 MHz when it is 0. Until the window closes, the selection sits at its default of 0, which means 48 MHz. A done flag tells downstream logic that the selection is final. The stored bit is cleared only when power-good drops, which stands for a power cycle.

All logic runs on the reference clock. The window length is a parameter counted in reference cycles. The pin level passes through a synchronizer before it is stored.

Top module: `pin_strap_ctrl`

## Requirements
- R1: While `pwr_good` is low at a rising clock edge, the block is reset: `pin_oe`, `strap_done`, `sel_24m` and `pin_o` are all 0 after that edge.
- R2: After the first rising edge with `pwr_good` high, `pin_oe` stays 0 for the next WINDOW_CYCLES-1 edges. It becomes 1 at edge number WINDOW_CYCLES and then stays 1 while `pwr_good` remains high.
- R3: `strap_done` rises at the same edge as `pin_oe` and is equal to it at all times.
- R4: At the closing edge, `sel_24m` takes the level of `strap_in` as sampled two rising edges earlier (edge WINDOW_CYCLES-2), through a two-stage synchronizer. A stored 1 means 24 MHz; a stored 0 means 48 MHz. A level first presented at edge WINDOW_CYCLES-1 or later is not stored.
- R5: `sel_24m` stays at its default 0 (48 MHz) for as long as `strap_done` is 0, whatever `strap_in` does.
- R6: Once `strap_done` is 1, changes on `strap_in` have no effect on `sel_24m`.
- R7: `pin_o` is 0 whenever `pin_oe` is 0. Whenever `pin_oe` is 1, `pin_o` equals `ref_wave` as sampled at the previous rising edge.
- R8: Only a low `pwr_good` clears the stored bit. Raising it again starts a new window, and that window stores a new value.
- R9: If `pwr_good` drops in the middle of a window, the count is abandoned. The next window lasts the full WINDOW_CYCLES edges, counted from the edge where `pwr_good` is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the window counter runs on it |
| pwr_good | input | 1 | Supply-good indication; low acts as a synchronous power-on reset |
| strap_in | input | 1 | Level read back from the shared pin |
| ref_wave | input | 1 | Reference clock waveform, as data, to be driven onto the pin |
| pin_oe | output | 1 | Output enable of the pin driver; 0 means high impedance |
| pin_o | output | 1 | Data driven onto the pin when enabled |
| strap_done | output | 1 | Window closed and the strap value is final |
| sel_24m | output | 1 | Stored strap: 1 selects 24 MHz, 0 selects 48 MHz |

## Verification
The bench targets the window edges. It looks at the edge just before the window closes and the closing edge itself, so a counter that is off by one shows up as an enable that is one cycle early or late. It changes the strap level at the last edge the synchronizer can still carry into the store, and at the first edge it cannot. A design with the wrong synchronizer depth stores the wrong value in one of those two cases. It toggles the strap after the window closes; a store that is not sticky follows the pin and changes the frequency selection. It also drops power-good in the middle of a window; a timer that is not restarted opens the driver early.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Number of synchronizer flops on the strap input.
  localparam int unsigned SYNC_DEPTH = 2;
  // Rate codes for the companion output.
  typedef enum logic {
    RATE_48M = 1'b0,
    RATE_24M = 1'b1
  } rate_sel_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned STAGES = strap_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst,
  output logic win_last,
  output logic win_done
);
  localparam int unsigned CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign win_last = !done_q && (cnt_q == LAST_CNT);
  assign win_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (win_last) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic clk,
  input  logic rst,
  input  logic win_last,
  input  logic strap_s,
  output logic sel_24m
);
  import strap_pkg::*;

  rate_sel_e rate_q;

  always_ff @(posedge clk) begin
    if (rst)           rate_q <= RATE_48M;
    else if (win_last) rate_q <= rate_sel_e'(strap_s);
  end

  assign sel_24m = (rate_q == RATE_24M);
endmodule

// File: rtl/pin_strap_ctrl.sv
module pin_strap_ctrl #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic strap_in,
  input  logic ref_wave,
  output logic pin_oe,
  output logic pin_o,
  output logic strap_done,
  output logic sel_24m
);
  logic rst;
  logic strap_s;
  logic win_last;
  logic win_done;
  logic drive_q;

  assign rst = !pwr_good;

  strap_sync #(.STAGES(strap_pkg::SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (strap_in),
    .d_out (strap_s)
  );

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .win_last (win_last),
    .win_done (win_done)
  );

  strap_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .win_last (win_last),
    .strap_s  (strap_s),
    .sel_24m  (sel_24m)
  );

  // Driver data starts at the same edge the enable opens.
  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= (win_done || win_last) && ref_wave;
  end

  assign pin_o      = drive_q;
  assign pin_oe     = win_done;
  assign strap_done = win_done;
endmodule

// File: rtl/pin_strap_ctrl_chk.sv
module pin_strap_ctrl_chk #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input logic clk,
  input logic pwr_good,
  input logic ref_wave,
  input logic pin_oe,
  input logic pin_o,
  input logic strap_done,
  input logic sel_24m
);
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] WIN_V = CW'(WINDOW_CYCLES);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!pwr_good)             since_q <= '0;
    else if (since_q != WIN_V) since_q <= since_q + 1'b1;
  end

  // R2
  oe_early_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (since_q < WIN_V) |-> !pin_oe);
  // R2
  oe_late_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (since_q == WIN_V) |-> pin_oe);
  // R3
  done_match_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    strap_done == pin_oe);
  // R5
  sel_default_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !strap_done |-> !sel_24m);
  // R6
  sel_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    strap_done |=> $stable(sel_24m));
  // R7
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !pin_oe |-> !pin_o);
  // R7
  pin_follow_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    pin_oe |-> (pin_o == $past(ref_wave)));
endmodule

bind pin_strap_ctrl pin_strap_ctrl_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk        (clk),
  .pwr_good   (pwr_good),
  .ref_wave   (ref_wave),
  .pin_oe     (pin_oe),
  .pin_o      (pin_o),
  .strap_done (strap_done),
  .sel_24m    (sel_24m)
);

// File: tb/pin_strap_ctrl_test.sv
`timescale 1ns/1ps
module pin_strap_ctrl_test;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic pwr_good = 1'b0;
  logic strap_in = 1'b0;
  logic ref_wave = 1'b0;
  logic pin_oe, pin_o, strap_done, sel_24m;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pin_strap_ctrl #(.WINDOW_CYCLES(WIN)) uut (
    .clk(clk), .pwr_good(pwr_good), .strap_in(strap_in), .ref_wave(ref_wave),
    .pin_oe(pin_oe), .pin_o(pin_o), .strap_done(strap_done), .sel_24m(sel_24m)
  );

  // Reference waveform changes 1 ns after each rising edge.
  initial forever begin
    @(posedge clk);
    #1 ref_wave = ~ref_wave;
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // R1: hold reset, check quiet outputs, then release with a strap level.
  task automatic power_up(input logic strap);
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {pin_oe, strap_done, sel_24m, pin_o}, 4'b0000);
    strap_in = strap;
    pwr_good = 1'b1;
  endtask

  // Runs one window. At negedge after edge flip_k, strap_in becomes flip_v.
  task automatic run_window(input logic exp_sel, input int flip_k, input logic flip_v);
    logic bad_oe = 1'b0;
    logic bad_sel = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == flip_k) strap_in = flip_v;
      if (k < WIN) begin
        if (pin_oe || strap_done || pin_o) bad_oe = 1'b1;
        if (sel_24m) bad_sel = 1'b1;
      end
      if (k == WIN - 1)
        check("R2 oe low one edge before close", {3'b0, pin_oe}, 4'b0000);
    end
    check("R2/R7 driver quiet during window", {3'b0, bad_oe}, 4'b0000);
    check("R5 default rate during window", {3'b0, bad_sel}, 4'b0000);
    check("R2/R3 oe and done at close", {2'b0, pin_oe, strap_done}, 4'b0011);
    check("R4 stored strap", {3'b0, sel_24m}, {3'b0, exp_sel});
  endtask

  task automatic t_basic_high;
    power_up(1'b1);
    run_window(1'b1, 0, 1'b0);
  endtask

  task automatic t_ignore_after_done;
    strap_in = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 strap change after done ignored", {3'b0, sel_24m}, 4'b0001);
    strap_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 sel still held", {3'b0, sel_24m}, 4'b0001);
  endtask

  task automatic t_pin_drive;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 pin follows reference", {3'b0, pin_o}, {3'b0, ~ref_wave});
    end
  endtask

  task automatic t_repower_low;
    power_up(1'b0);
    check("R8 store cleared by power loss", {3'b0, sel_24m}, 4'b0000);
    run_window(1'b0, 0, 1'b0);
  endtask

  task automatic t_late_capture;
    power_up(1'b0);
    run_window(1'b1, WIN - 3, 1'b1);   // sampled at edge WIN-2: stored
    power_up(1'b0);
    run_window(1'b0, WIN - 2, 1'b1);   // sampled at edge WIN-1: too late
  endtask

  task automatic t_restart_mid;
    power_up(1'b0);
    repeat (20) @(negedge clk);
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset mid-window", {pin_oe, strap_done, sel_24m, pin_o}, 4'b0000);
    strap_in = 1'b1;
    pwr_good = 1'b1;
    run_window(1'b1, 0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_basic_high();
    t_ignore_after_done();
    t_pin_drive();
    t_repower_low();
    t_late_capture();
    t_restart_mid();
    t_pin_drive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule